// File: doc/BRIEF.md
# Keyed Watchdog / Interval Timer

This block is a single free-running counter that serves one of two roles, chosen by a mode bit in its control register. In watchdog mode, the counter runs out after the selected interval and the block issues a one-cycle system reset. Software must clear the counter often enough to keep that from happening. In interval mode, the same run-out sets an interrupt flag, the counter wraps, and counting goes on, so the flag rises at a fixed period.

The control register sits on a simple 16-bit register write port. Every write must carry a fixed key in its upper byte. A write with any other upper byte is not applied. It counts as a violation: it issues the system reset and sets the flag. After the block issues a reset, it returns to its defaults, which are watchdog mode with the longest interval. The flag survives that reset, so software can see why the reset happened. Only the external reset or an explicit acknowledge clears the flag.

Top module: `wdt_interval_timer`

## Requirements
- R1: After `rst`, `rd_data` reads 16'h6900 and both `sys_rst` and `irq` are 0. The upper read byte is always 8'h69.
- R2: A write whose `wr_data[15:8]` is not 8'h5A changes no field. It drives `sys_rst` high in the cycle after the write edge and sets the flag.
- R3: A write with key 8'h5A loads the fields from `wr_data[7:0]`: hold = bit 7, mode = bit 4 (1 = interval), ie = bit 2, sel = bits 1:0. Readback `rd_data[7:0]` is {hold, 0, flag, mode, 0, ie, sel}.
- R4: In watchdog mode, `sys_rst` is high for exactly one cycle after the N-th counted cycle since the last clear, and the flag is set. N is 2^15, 2^13, 2^9 or 2^6 for sel 0, 1, 2 or 3.
- R5: In the cycle after a `sys_rst` pulse, the fields are back at hold 0, mode 0, ie 0 and sel 0, and the counter is zero. The flag keeps its value, so `rd_data` reads 16'h6920.
- R6: In interval mode, each run-out sets the flag without any `sys_rst`. The counter then restarts from zero, so the flag repeats every N counted cycles.
- R7: `irq` is flag AND ie AND interval mode. In watchdog mode, ie has no effect on `irq`.
- R8: A keyed write with bit 3 set zeroes the counter. Bit 3 always reads 0.
- R9: The counter advances only in cycles where `cnt_en` is 1 and hold is 0.
- R10: The flag is cleared only by `rst` or by a keyed write with bit 6 set. Bit 6 reads 0. If a set and a clear happen on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on / pin reset |
| cnt_en | input | 1 | Count enable from the selected time base |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Write data: key in [15:8], fields in [7:0] |
| rd_data | output | 16 | Control register readback |
| sys_rst | output | 1 | One-cycle system reset request |
| irq | output | 1 | Interval interrupt request |

## Verification
Some behaviours are checked by the assertions on every cycle. These are the reset response to a bad key, the single-cycle reset pulse, the defaults after it, the freeze of the counter while stepping is off, and the stickiness of the flag. The `irq`-only-in-interval-mode rule is also checked on every cycle. Other behaviours need the bench's scenarios: the exact run-out cycle for each interval select, the periodic repeat in interval mode, a clear or a hold in the middle of a count, and ie having no effect in watchdog mode.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned DATA_W  = 16;
    localparam int unsigned NUM_TAP = 4;
    localparam logic [7:0]  KEY_WR  = 8'h5A;
    localparam logic [7:0]  KEY_RD  = 8'h69;

    typedef enum logic {
        MODE_WDOG = 1'b0,
        MODE_IVL  = 1'b1
    } wdt_mode_e;

    typedef struct packed {
        logic      hold;
        wdt_mode_e mode;
        logic      ie;
        logic [1:0] sel;
    } wdt_ctrl_t;

    typedef struct packed {
        logic good;
        logic bad;
        logic clr;
        logic ack;
    } wdt_cmd_t;

    localparam wdt_ctrl_t CTRL_DEFAULT = '{hold: 1'b0, mode: MODE_WDOG, ie: 1'b0, sel: 2'd0};

    function automatic wdt_ctrl_t decode_fields(input logic [7:0] b);
        wdt_ctrl_t c;
        c.hold = b[7];
        c.mode = wdt_mode_e'(b[4]);
        c.ie   = b[2];
        c.sel  = b[1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_read(input wdt_ctrl_t c, input logic flag);
        return {KEY_RD, c.hold, 1'b0, flag, c.mode, 1'b0, c.ie, c.sel};
    endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output wdt_ctrl_t         ctrl_q,
    output wdt_cmd_t          cmd
);

    logic key_ok;

    always_comb begin
        key_ok   = (wr_data[DATA_W-1:8] == KEY_WR);
        cmd.good = wr_en && key_ok && !wipe;
        cmd.bad  = wr_en && !key_ok && !wipe;
        cmd.clr  = cmd.good && wr_data[3];
        cmd.ack  = cmd.good && wr_data[6];
    end

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            ctrl_q <= CTRL_DEFAULT;
        end else if (cmd.good) begin
            ctrl_q <= decode_fields(wr_data[7:0]);
        end
    end

    // R3
    keyed_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wipe && wr_data[DATA_W-1:8] == KEY_WR)
        |=> (ctrl_q == decode_fields($past(wr_data[7:0]))));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned NUM_TAP = 4,
    parameter int unsigned TAP_EXP [NUM_TAP] = '{15, 13, 9, 6}
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       step,
    input  logic                       clr,
    input  logic [$clog2(NUM_TAP)-1:0] sel,
    output logic                       expire
);

    localparam logic [CNT_W:0] ONE = 1;

    logic [CNT_W-1:0] lim_tab [NUM_TAP];
    logic [CNT_W-1:0] cnt_q;

    for (genvar g = 0; g < NUM_TAP; g++) begin : g_tap
        assign lim_tab[g] = CNT_W'((ONE << TAP_EXP[g]) - 1'b1);
    end

    assign expire = !rst && !clr && step && (cnt_q >= lim_tab[sel]);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (expire) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !clr) |=> $stable(cnt_q));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned TAP_EXP [NUM_TAP] = '{15, 13, 9, 6}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              sys_rst,
    output logic              irq
);

    wdt_ctrl_t ctrl_q;
    wdt_cmd_t  cmd;
    logic      sys_rst_q;
    logic      flag_q;
    logic      expire;
    logic      step;
    logic      core_rst;

    assign core_rst = rst || sys_rst_q;
    assign step     = cnt_en && !ctrl_q.hold;

    wdt_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wipe    (sys_rst_q),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .cmd     (cmd)
    );

    wdt_counter #(
        .CNT_W   (CNT_W),
        .NUM_TAP (NUM_TAP),
        .TAP_EXP (TAP_EXP)
    ) u_cnt (
        .clk    (clk),
        .rst    (core_rst),
        .step   (step),
        .clr    (cmd.clr),
        .sel    (ctrl_q.sel),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_rst_q <= 1'b0;
            flag_q    <= 1'b0;
        end else begin
            sys_rst_q <= !sys_rst_q && (cmd.bad || (expire && ctrl_q.mode == MODE_WDOG));
            if (cmd.bad || expire) begin
                flag_q <= 1'b1;
            end else if (cmd.ack) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign rd_data = pack_read(ctrl_q, flag_q);
    assign sys_rst = sys_rst_q;
    assign irq     = flag_q && ctrl_q.ie && (ctrl_q.mode == MODE_IVL);

    // R2
    bad_key_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sys_rst && wr_data[15:8] != KEY_WR) |=> (sys_rst && rd_data[5]));

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst |=> !sys_rst);

    // R5
    defaults_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst |=> (rd_data == {KEY_RD, 8'h20}));

    // R7
    irq_mode_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rd_data[4] && rd_data[2] && rd_data[5]));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[5] && !(wr_en && wr_data[15:8] == KEY_WR && wr_data[6])) |=> rd_data[5]);

endmodule

// File: tb/test_wdt_interval_timer.sv
module test_wdt_interval_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        sys_rst;
    logic        irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    wdt_interval_timer i_wdt_interval_timer (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .sys_rst(sys_rst), .irq(irq)
    );

    function automatic int unsigned period(input logic [1:0] s);
        case (s)
            2'd0: return 32768;
            2'd1: return 8192;
            2'd2: return 512;
            default: return 64;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic steps(input int unsigned n);
        for (int unsigned i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        steps(3);
        rst = 1'b0;
        // R1 reset state
        chk("R1 rd", rd_data, 16'h6900);
        chk("R1 sys_rst", {15'd0, sys_rst}, 16'd0);
        chk("R1 irq", {15'd0, irq}, 16'd0);

        // R4 watchdog, longest interval
        wr(16'h5A08);
        steps(32767);
        chk("R4 no early rst", {15'd0, sys_rst}, 16'd0);
        steps(1);
        chk("R4 rst at N", {15'd0, sys_rst}, 16'd1);
        chk("R4 flag", {15'd0, rd_data[5]}, 16'd1);
        steps(1);
        chk("R5 defaults", rd_data, 16'h6920);
        chk("R5 pulse width", {15'd0, sys_rst}, 16'd0);

        // R10 acknowledge
        wr(16'h5A40);
        chk("R10 ack", rd_data, 16'h6900);

        // R2 bad key
        wr(16'h1234);
        chk("R2 rst", {15'd0, sys_rst}, 16'd1);
        steps(1);
        chk("R2 not applied", rd_data, 16'h6920);

        // R3 field readback, R8/R10 read zero
        wr(16'h5ADF);
        chk("R3 readback", rd_data, 16'h6997);

        // R7 ie no effect in watchdog mode
        wr(16'h5A4F);
        steps(63);
        chk("R7 no rst yet", {15'd0, sys_rst}, 16'd0);
        steps(1);
        chk("R7 wd rst", {15'd0, sys_rst}, 16'd1);
        chk("R7 irq quiet", {15'd0, irq}, 16'd0);
        steps(1);

        // R6 interval mode with irq
        wr(16'h5A5F);
        steps(63);
        chk("R6 flag early", {15'd0, rd_data[5]}, 16'd0);
        steps(1);
        chk("R6 flag", {15'd0, rd_data[5]}, 16'd1);
        chk("R7 irq", {15'd0, irq}, 16'd1);
        chk("R6 no rst", {15'd0, sys_rst}, 16'd0);
        wr(16'h5A57);
        steps(62);
        chk("R6 period early", {15'd0, rd_data[5]}, 16'd0);
        steps(1);
        chk("R6 periodic", {15'd0, rd_data[5]}, 16'd1);

        // R9 hold
        wr(16'h5A5B);
        steps(30);
        wr(16'h5A93);
        steps(100);
        chk("R9 hold", {15'd0, rd_data[5]}, 16'd0);
        wr(16'h5A13);
        steps(32);
        chk("R9 resume early", {15'd0, rd_data[5]}, 16'd0);
        steps(1);
        chk("R9 resume", {15'd0, rd_data[5]}, 16'd1);

        // R9 cnt_en low
        wr(16'h5A5B);
        cnt_en = 1'b0;
        steps(200);
        chk("R9 cnt_en", {15'd0, rd_data[5]}, 16'd0);
        cnt_en = 1'b1;
        steps(63);
        chk("R9 en early", {15'd0, rd_data[5]}, 16'd0);
        steps(1);
        chk("R9 en expire", {15'd0, rd_data[5]}, 16'd1);

        // R8 clear mid-count
        wr(16'h5A5B);
        steps(40);
        wr(16'h5A1B);
        steps(63);
        chk("R8 cleared", {15'd0, rd_data[5]}, 16'd0);
        steps(1);
        chk("R8 expire", {15'd0, rd_data[5]}, 16'd1);

        // random interval runs and bad keys
        for (int it = 0; it < 12; it++) begin
            logic [1:0] s;
            logic       ie;
            logic [7:0] k;
            s  = 2'(1 + ($urandom % 3));
            ie = 1'($urandom % 2);
            wr({8'h5A, 8'h58 | {5'd0, ie, 2'd0} | {6'd0, s}});
            steps(period(s) - 1);
            chk("R6 rand early", {15'd0, rd_data[5]}, 16'd0);
            steps(1);
            chk("R6 rand flag", {15'd0, rd_data[5]}, 16'd1);
            chk("R7 rand irq", {15'd0, irq}, {15'd0, ie});
            chk("R6 rand no rst", {15'd0, sys_rst}, 16'd0);
            k = 8'($urandom);
            if (k == 8'h5A) k = 8'hA5;
            wr({k, 8'($urandom)});
            chk("R2 rand rst", {15'd0, sys_rst}, 16'd1);
            steps(1);
            chk("R5 rand defaults", rd_data, 16'h6920);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule